// File: doc/BRIEF.md
# IDE PIO Strobe Timing Generator

This block sequences one programmed-I/O access on a parallel ATA channel, clocked by the host bus clock. Each access has three phases in a fixed order. In the address-setup phase the address is valid and the strobe is idle. In the active phase the read/write strobe is asserted. In the recovery phase the bus is quiet until the next access may begin.

Timing is held per drive slot. Drives 0 and 1 each own a setup register and a timing register. Drives 2 and 3 share one pair. A start request names a drive. The block latches that drive's decoded phase lengths and runs the access. While it runs, busy is high. In the last recovery clock it pulses done.

A chip revision input decides whether the recovery phase gets one extra clock.

Top module: `pio_strobe_gen`

## Requirements
- R1: The setup phase length comes from bits [7:6] of the selected setup register: 00 gives 4 clocks, 01 gives 2, 10 gives 3 and 11 gives 5.
- R2: In the timing byte, bits [7:4] are the active count and bits [3:0] are the recovery count. A zero nibble means 16 clocks; any other nibble means its own value.
- R3: An active count of 1 runs as 2 clocks.
- R4: When the effective active length is greater than 3, a recovery count of 1 runs as 2 clocks.
- R5: If the revision input is greater than 1, recovery lasts one clock longer than the count from R2 and R4. If it is 0 or 1, recovery lasts exactly that count.
- R6: Register addresses are: drive 0 setup 0 and timing 1; drive 1 setup 2 and timing 3; shared setup 4 and timing 5, used by both drive 2 and drive 3. Writing one drive's pair does not change another slot's timing.
- R7: Phases run setup, then active, then recovery. The strobe is high only in active. Address-valid is high in setup and active and low in recovery.
- R8: Busy is high from the clock after an accepted start through the last recovery clock. Done is high for exactly one clock, the last recovery clock.
- R9: A start request seen while busy is ignored. It neither restarts nor extends the running access, and no further access follows it.
- R10: Timing is sampled when a start is accepted. A register write during an access affects only later accesses.
- R11: After reset all six registers read 0x00, the block is idle, and an access takes 4 setup clocks and 16 active clocks.
- R12: Bits [5:0] of a setup register are stored and read back, and have no effect on timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Host bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rev_i | input | 2 | Chip revision field |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 8 | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | 8 | Register read data, combinational |
| start_i | input | 1 | Access start request |
| drive_i | input | 2 | Drive index for the request |
| addr_valid_o | output | 1 | Address-valid enable |
| strobe_o | output | 1 | Read/write strobe enable |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | Last recovery clock of an access |

## Verification
A full sweep covers every setup code, active nibble and recovery nibble under both revision classes, and measures each phase at the outputs. The sweep separates the zero-means-16 rule from the two stretch rules, and it separates the stretch of a recovery count of 1 when active is long from the unstretched case when active is 3 or less. Directed accesses on all four drives tell private slots from the shared slot. Starts and register writes injected mid-access tell sample-at-start behaviour from live register use, and show that a start during an access is dropped. Setup registers written with varied low bits show those bits are stored but not decoded.

// File: rtl/pio_strobe_pkg.sv
`timescale 1ns/1ps
package pio_strobe_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned NIB_W  = DATA_W / 2;
  localparam int unsigned CNT_W  = NIB_W + 1;

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_ACT, PH_REC} phase_e;

  typedef struct packed {
    logic [CNT_W-1:0] setup_n;
    logic [CNT_W-1:0] act_n;
    logic [CNT_W-1:0] rec_n;
  } xfer_cnt_t;
endpackage

// File: rtl/pio_timing_regs.sv
`timescale 1ns/1ps
module pio_timing_regs
  import pio_strobe_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 3,
  localparam int unsigned ADDR_W = $clog2(NUM_SLOTS) + 1,
  localparam int unsigned SLOT_AW = ADDR_W - 1
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              we_i,
  input  logic [ADDR_W-1:0]                 waddr_i,
  input  logic [DATA_W-1:0]                 wdata_i,
  input  logic [ADDR_W-1:0]                 raddr_i,
  output logic [DATA_W-1:0]                 rdata_o,
  output logic [NUM_SLOTS-1:0][DATA_W-1:0]  setup_q_o,
  output logic [NUM_SLOTS-1:0][DATA_W-1:0]  timing_q_o
);

  // addr[0] picks timing vs setup, upper bits pick the slot
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      setup_q_o  <= '0;
      timing_q_o <= '0;
    end else if (we_i) begin
      for (int s = 0; s < int'(NUM_SLOTS); s++) begin
        if (waddr_i[ADDR_W-1:1] == SLOT_AW'(s)) begin
          if (waddr_i[0]) timing_q_o[s] <= wdata_i;
          else            setup_q_o[s]  <= wdata_i;
        end
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int s = 0; s < int'(NUM_SLOTS); s++) begin
      if (raddr_i[ADDR_W-1:1] == SLOT_AW'(s))
        rdata_o = raddr_i[0] ? timing_q_o[s] : setup_q_o[s];
    end
  end

endmodule

// File: rtl/pio_timing_decode.sv
`timescale 1ns/1ps
module pio_timing_decode
  import pio_strobe_pkg::*;
#(
  parameter int unsigned NUM_SLOTS   = 3,
  parameter int unsigned PRIV_DRIVES = 2,
  parameter int unsigned DRV_W       = 2
) (
  input  logic [NUM_SLOTS-1:0][DATA_W-1:0] setup_q_i,
  input  logic [NUM_SLOTS-1:0][DATA_W-1:0] timing_q_i,
  input  logic [DRV_W-1:0]                 drive_i,
  input  logic [1:0]                       rev_i,
  output xfer_cnt_t                        cnt_o
);

  localparam logic [CNT_W-1:0] ZERO_MEANS = CNT_W'(1 << NIB_W);

  int               sel;
  logic [DATA_W-1:0] su_reg;
  logic [DATA_W-1:0] tm_reg;
  logic [1:0]        su_code;
  logic [NIB_W-1:0]  a_raw;
  logic [NIB_W-1:0]  r_raw;
  logic [CNT_W-1:0]  act_n;
  logic [CNT_W-1:0]  rec_n;

  // drives above the private range fold onto the shared slot
  always_comb begin
    sel = (int'(drive_i) < int'(PRIV_DRIVES)) ? int'(drive_i) : int'(PRIV_DRIVES);
    su_reg = '0;
    tm_reg = '0;
    for (int s = 0; s < int'(NUM_SLOTS); s++) begin
      if (s == sel) begin
        su_reg = setup_q_i[s];
        tm_reg = timing_q_i[s];
      end
    end
  end

  always_comb begin
    su_code = su_reg[DATA_W-1 -: 2];
    a_raw   = tm_reg[DATA_W-1 -: NIB_W];
    r_raw   = tm_reg[NIB_W-1:0];

    unique case (su_code)
      2'b00:   cnt_o.setup_n = CNT_W'(4);
      2'b10:   cnt_o.setup_n = CNT_W'(3);
      2'b01:   cnt_o.setup_n = CNT_W'(2);
      default: cnt_o.setup_n = CNT_W'(5);
    endcase

    if (a_raw == '0)              act_n = ZERO_MEANS;
    else if (a_raw == NIB_W'(1))  act_n = CNT_W'(2);
    else                          act_n = CNT_W'(a_raw);

    if (r_raw == '0) rec_n = ZERO_MEANS;
    else             rec_n = CNT_W'(r_raw);
    if (r_raw == NIB_W'(1) && act_n > CNT_W'(3)) rec_n = CNT_W'(2);
    if (rev_i > 2'd1) rec_n = rec_n + CNT_W'(1);

    cnt_o.act_n = act_n;
    cnt_o.rec_n = rec_n;
  end

endmodule

// File: rtl/pio_phase_seq.sv
`timescale 1ns/1ps
module pio_phase_seq
  import pio_strobe_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      start_i,
  input  xfer_cnt_t cnt_i,
  output logic      addr_valid_o,
  output logic      strobe_o,
  output logic      busy_o,
  output logic      done_o
);

  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] act_q;
  logic [CNT_W-1:0] rec_q;
  logic             last_clk;

  assign last_clk = (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      act_q   <= '0;
      rec_q   <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (start_i) begin
          phase_q <= PH_SETUP;
          cnt_q   <= cnt_i.setup_n;
          act_q   <= cnt_i.act_n;
          rec_q   <= cnt_i.rec_n;
        end
        PH_SETUP: if (last_clk) begin
          phase_q <= PH_ACT;
          cnt_q   <= act_q;
        end else cnt_q <= cnt_q - CNT_W'(1);
        PH_ACT: if (last_clk) begin
          phase_q <= PH_REC;
          cnt_q   <= rec_q;
        end else cnt_q <= cnt_q - CNT_W'(1);
        PH_REC: if (last_clk) begin
          phase_q <= PH_IDLE;
          cnt_q   <= '0;
        end else cnt_q <= cnt_q - CNT_W'(1);
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign addr_valid_o = (phase_q == PH_SETUP) || (phase_q == PH_ACT);
  assign strobe_o     = (phase_q == PH_ACT);
  assign busy_o       = (phase_q != PH_IDLE);
  assign done_o       = (phase_q == PH_REC) && last_clk;

endmodule

// File: rtl/pio_strobe_gen.sv
`timescale 1ns/1ps
module pio_strobe_gen
  import pio_strobe_pkg::*;
#(
  parameter int unsigned NUM_DRIVES  = 4,
  parameter int unsigned PRIV_DRIVES = 2,
  localparam int unsigned NUM_SLOTS = PRIV_DRIVES + 1,
  localparam int unsigned ADDR_W    = $clog2(NUM_SLOTS) + 1,
  localparam int unsigned DRV_W     = $clog2(NUM_DRIVES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        rev_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              start_i,
  input  logic [DRV_W-1:0]  drive_i,
  output logic              addr_valid_o,
  output logic              strobe_o,
  output logic              busy_o,
  output logic              done_o
);

  logic [NUM_SLOTS-1:0][DATA_W-1:0] setup_q;
  logic [NUM_SLOTS-1:0][DATA_W-1:0] timing_q;
  xfer_cnt_t                        cnt;

  pio_timing_regs #(.NUM_SLOTS(NUM_SLOTS)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (wr_en_i),
    .waddr_i    (wr_addr_i),
    .wdata_i    (wr_data_i),
    .raddr_i    (rd_addr_i),
    .rdata_o    (rd_data_o),
    .setup_q_o  (setup_q),
    .timing_q_o (timing_q)
  );

  pio_timing_decode #(
    .NUM_SLOTS   (NUM_SLOTS),
    .PRIV_DRIVES (PRIV_DRIVES),
    .DRV_W       (DRV_W)
  ) u_decode (
    .setup_q_i  (setup_q),
    .timing_q_i (timing_q),
    .drive_i    (drive_i),
    .rev_i      (rev_i),
    .cnt_o      (cnt)
  );

  pio_phase_seq u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .cnt_i        (cnt),
    .addr_valid_o (addr_valid_o),
    .strobe_o     (strobe_o),
    .busy_o       (busy_o),
    .done_o       (done_o)
  );

endmodule

// File: rtl/pio_strobe_gen_chk.sv
`timescale 1ns/1ps
module pio_strobe_gen_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic addr_valid_o,
  input logic strobe_o,
  input logic busy_o,
  input logic done_o
);

  AST_STROBE_IN_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |-> addr_valid_o && busy_o); // R7

  AST_START_SETUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> busy_o && addr_valid_o && !strobe_o); // R7

  AST_REC_NO_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !addr_valid_o |=> !strobe_o); // R7

  AST_STROBE_MIN_TWO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(strobe_o) |=> strobe_o); // R3

  AST_DONE_IN_REC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o && !addr_valid_o); // R8

  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !addr_valid_o && !strobe_o && !done_o); // R8

  AST_BUSY_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !done_o |=> busy_o); // R9

endmodule

bind pio_strobe_gen pio_strobe_gen_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .addr_valid_o (addr_valid_o),
  .strobe_o     (strobe_o),
  .busy_o       (busy_o),
  .done_o       (done_o)
);

// File: tb/pio_strobe_gen_tb.sv
`timescale 1ns/1ps
module pio_strobe_gen_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] rev = 2'd1;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       start = 1'b0;
  logic [1:0] drive = '0;
  logic       av, stb, busy, done;

  int checks = 0;
  int fails  = 0;
  int inj_addr = 0;
  int inj_data = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  pio_strobe_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .rev_i(rev),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .start_i(start), .drive_i(drive),
    .addr_valid_o(av), .strobe_o(stb), .busy_o(busy), .done_o(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_setup(input int code);
    case (code)
      0: return 4;
      2: return 3;
      1: return 2;
      default: return 5;
    endcase
  endfunction

  function automatic int exp_act(input int n);
    if (n == 0) return 16;
    if (n == 1) return 2;
    return n;
  endfunction

  function automatic int exp_rec(input int an, input int rn, input int rv);
    int r;
    r = (rn == 0) ? 16 : rn;
    if (rn == 1 && exp_act(an) > 3) r = 2;
    if (rv > 1) r = r + 1;
    return r;
  endfunction

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_check(input int a, input int exp, input string req);
    @(negedge clk);
    rd_addr = 3'(a);
    #1;
    check(rd_data == 8'(exp), req, int'(rd_data), exp);
  endtask

  // inj: 0 none, 1 start on other drive mid-access, 2 register write mid-access
  task automatic xfer(input int drv, input int inj, input int es, input int ea, input int er,
                      input string req);
    int s, a, r, nd, bad, total, done_at, prev, ph;
    s = 0; a = 0; r = 0; nd = 0; bad = 0; total = 0; done_at = -1; prev = 0;
    @(negedge clk);
    start = 1'b1; drive = 2'(drv);
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 80; i++) begin
      if (busy) begin
        total++;
        ph = stb ? 1 : (av ? 0 : 2);
        if (stb && !av) bad++;
        if (ph < prev) bad++;
        prev = ph;
        if (ph == 0) s++; else if (ph == 1) a++; else r++;
        if (done) begin nd++; done_at = total; end
      end else begin
        if (av || stb || done) bad++;
        break;
      end
      if (i == 1 && inj == 1) begin start = 1'b1; drive = 2'(drv ^ 1); end
      if (i == 1 && inj == 2) begin wr_en = 1'b1; wr_addr = 3'(inj_addr); wr_data = 8'(inj_data); end
      if (i == 2) begin start = 1'b0; wr_en = 1'b0; end
      @(negedge clk);
    end
    check(s == es && a == ea && r == er, req, s*10000 + a*100 + r, es*10000 + ea*100 + er);
    check(bad == 0, "R7", bad, 0);
    check(nd == 1 && done_at == total && total > 0, "R8", nd*1000 + done_at, 1000 + total);
  endtask

  initial begin
    #(8 * 190000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL R8 watchdog actual=busy expected=idle");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    #1;
    check(!busy && !av && !stb && !done, "R11", int'({busy, av, stb, done}), 0);
    for (int k = 0; k < 6; k++) rd_check(k, 0, "R11");
    xfer(2, 0, 4, 16, 16, "R11");

    // R12 low setup bits stored, not decoded
    wr(0, 8'h3F);
    rd_check(0, 8'h3F, "R12");
    xfer(0, 0, 4, 16, 16, "R12");
    wr(0, 8'hD5);
    rd_check(0, 8'hD5, "R12");
    xfer(0, 0, 5, 16, 16, "R12");

    // R6 shared slot and private slots
    wr(4, 8'hC0); wr(5, 8'h23);
    xfer(2, 0, 5, 2, 3, "R6");
    xfer(3, 0, 5, 2, 3, "R6");
    wr(0, 8'h40); wr(1, 8'h45);
    wr(2, 8'h80); wr(3, 8'h67);
    rd_check(5, 8'h23, "R6");
    xfer(0, 0, 2, 4, 5, "R6");
    xfer(1, 0, 3, 6, 7, "R6");
    xfer(2, 0, 5, 2, 3, "R6");

    // R9 start during busy ignored
    xfer(0, 1, 2, 4, 5, "R9");
    @(negedge clk);
    check(!busy, "R9", int'(busy), 0);

    // R10 mid-access write affects only the next access
    inj_addr = 1; inj_data = 8'h92;
    xfer(0, 2, 2, 4, 5, "R10");
    xfer(0, 0, 2, 9, 2, "R10");

    // R5 revision spot checks: 0 behaves as 1, 3 behaves as 2
    rev = 2'd0; xfer(1, 0, 3, 6, 7, "R5");
    rev = 2'd3; xfer(1, 0, 3, 6, 8, "R5");

    // full sweep: rev 1 on drive 0, rev 2 on drive 1
    for (int rv = 1; rv <= 2; rv++) begin
      int base;
      rev = 2'(rv);
      base = (rv == 1) ? 0 : 2;
      for (int code = 0; code < 4; code++) begin
        wr(base, (code << 6) | 8'h15);
        for (int an = 0; an < 16; an++) begin
          for (int rn = 0; rn < 16; rn++) begin
            string tag;
            if (an == 1) tag = "R3";
            else if (rn == 1 && exp_act(an) > 3) tag = "R4";
            else if (rv > 1) tag = "R5";
            else if (an == 0 || rn == 0) tag = "R2";
            else tag = "R1";
            wr(base + 1, (an << 4) | rn);
            xfer(base / 2, 0, exp_setup(code), exp_act(an), exp_rec(an, rn, rv), tag);
          end
        end
      end
    end

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule